// File: doc/BRIEF.md
# In-Place Rectifier for a Dual-Port Feature Memory

This block rectifies a feature map that sits in a dual-port block memory. It does not copy the map. A start pulse begins a run. The block then reads every element through one memory port, one element per cycle, walking from the lowest address to the highest. Each value comes back after the memory's read latency. The block clamps it to zero when it is negative and returns it unchanged otherwise, then writes it through the second port to the location it came from.

The read address travels with a valid flag down a short shift chain. The chain is as deep as the read latency, so every write lands on the address whose data it carries. The run ends only after the chain has emptied. The block then drops busy and gives a one-cycle done pulse. Element count, data width and read latency are parameters.

Top module: `relu_inplace`

## Requirements
- R1: After reset, busy, done, rd_en and wr_en are all low.
- R2: A start pulse seen while idle raises busy in the next cycle. Starting in that cycle, rd_en stays high for exactly DEPTH consecutive cycles, and rd_addr goes 0, 1, … DEPTH-1 in those cycles.
- R3: Each write goes to the address that was read exactly RD_LAT cycles earlier. The memory returns read data RD_LAT cycles after rd_en.
- R4: Data are two's complement with the sign in bit DATA_W-1. When the returned value has that bit set, wr_data is zero. Otherwise wr_data equals the returned value.
- R5: Within a run, every address from 0 to DEPTH-1 is written exactly once, in increasing order, so the memory ends up holding the rectified map.
- R6: done is high for exactly one cycle, two cycles after the cycle of the final write. busy falls in that same cycle, so busy lasts DEPTH+RD_LAT+1 cycles.
- R7: rd_en and wr_en are high only while busy. No access follows done until the next start.
- R8: A start pulse while busy is ignored: the run keeps its length and issues no extra reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle run request |
| busy | output | 1 | High while a run is active |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Read request on the read port |
| rd_addr | output | $clog2(DEPTH) | Read address |
| rd_data | input | DATA_W | Read data, valid RD_LAT cycles after rd_en |
| wr_en | output | 1 | Write strobe on the write port |
| wr_addr | output | $clog2(DEPTH) | Write address |
| wr_data | output | DATA_W | Rectified value to store |

## Verification
The assertions check the following on every cycle:
- writes follow a strictly ascending address order and never carry a set sign bit;
- accesses happen only under busy;
- done lasts one cycle, comes without busy, and appears only after DEPTH writes.

Some behaviours only the bench scenarios can show:
- that each write carries the value read RD_LAT cycles earlier;
- that the final memory image equals the rectified original for mixed-sign, extreme and all-negative maps;
- that a start pulse during a run leaves the run length and the access counts unchanged.

// File: rtl/relu_inplace.sv
module relu_inplace #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int RD_LAT = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  output logic                                busy,
  output logic                                done,
  output logic                                rd_en,
  output logic [$clog2(DEPTH)-1:0]            rd_addr,
  input  logic [DATA_W-1:0]                   rd_data,
  output logic                                wr_en,
  output logic [$clog2(DEPTH)-1:0]            wr_addr,
  output logic [DATA_W-1:0]                   wr_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     rd_cnt;
  logic [RD_LAT-1:0] pv;
  logic [AW-1:0]     pa [RD_LAT];
  logic              busy_q, done_q;

  wire issuing = busy_q && (rd_cnt < CW'(DEPTH));

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_en   = issuing;
  assign rd_addr = rd_cnt[AW-1:0];
  assign wr_en   = pv[RD_LAT-1];
  assign wr_addr = pa[RD_LAT-1];
  assign wr_data = rd_data[DATA_W-1] ? '0 : rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rd_cnt <= '0;
      pv     <= '0;
    end else begin
      done_q <= 1'b0;
      for (int i = RD_LAT - 1; i > 0; i--) pv[i] <= pv[i-1];
      pv[0] <= issuing;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          rd_cnt <= '0;
        end
      end else if (issuing) begin
        rd_cnt <= rd_cnt + 1'b1;
      end else if (pv == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = RD_LAT - 1; i > 0; i--) pa[i] <= pa[i-1];
    pa[0] <= rd_addr;
  end

  logic [CW-1:0] wr_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) wr_seen <= '0;
    else if (!busy_q && start) wr_seen <= '0;
    else if (wr_en) wr_seen <= wr_seen + 1'b1;
  end

  assert_write_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} == {1'b0, wr_seen[AW-1:0]}) && (wr_seen < CW'(DEPTH)));
  assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_data[DATA_W-1]);
  assert_write_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
  assert_read_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && (wr_seen == CW'(DEPTH)));
endmodule

// File: tb/relu_inplace_test.sv
module relu_inplace_test;
  localparam int DW = 16;
  localparam int N  = 64;
  localparam int L  = 3;
  localparam int AW = $clog2(N);

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;

  always #10 clk = ~clk;

  relu_inplace #(.DATA_W(DW), .DEPTH(N), .RD_LAT(L)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  logic [DW-1:0] mem [N];
  logic [DW-1:0] orig [N];
  logic [DW-1:0] rq [L];
  assign rd_data = rq[L-1];

  always @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    for (int i = L - 1; i > 0; i--) rq[i] <= rq[i-1];
    rq[0] <= rd_en ? mem[rd_addr] : 'x;
  end

  int checks = 0, errors = 0;
  int cyc = 0;
  int rd_hist [int];
  int wcnt [N];
  int rd_n, wr_n, busy_n, last_wr, done_cyc, exp_rd, exp_wr, done_n;
  bit stray;

  function automatic logic [DW-1:0] relu(input logic [DW-1:0] v);
    return v[DW-1] ? '0 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy) busy_n++;
      if (done) begin done_cyc = cyc; done_n++; end
      if ((rd_en || wr_en) && !busy) stray = 1;
      if (rd_en) begin
        if (int'(rd_addr) != exp_rd) begin
          errors++; checks++;
          $display("FAIL R2 rd_addr actual=%0d expected=%0d", rd_addr, exp_rd);
        end
        rd_hist[cyc] = int'(rd_addr);
        exp_rd++; rd_n++;
      end
      if (wr_en) begin
        if (!rd_hist.exists(cyc - L) || rd_hist[cyc - L] != int'(wr_addr)) begin
          errors++; checks++;
          $display("FAIL R3 wr_addr actual=%0d expected=%0d", wr_addr,
                   rd_hist.exists(cyc - L) ? rd_hist[cyc - L] : -1);
        end
        if (int'(wr_addr) != exp_wr) begin
          errors++; checks++;
          $display("FAIL R5 wr order actual=%0d expected=%0d", wr_addr, exp_wr);
        end
        if (wr_data !== relu(orig[wr_addr])) begin
          errors++; checks++;
          $display("FAIL R4 wr_data actual=%0d expected=%0d", wr_data, relu(orig[wr_addr]));
        end
        wcnt[wr_addr]++;
        exp_wr++; wr_n++; last_wr = cyc;
      end
    end
  end

  task automatic run(input int mode, input bit poke);
    int first_busy;
    for (int i = 0; i < N; i++) begin
      case (mode)
        0: mem[i] = DW'($urandom);
        1: mem[i] = (i % 4 == 0) ? 16'h7FFF : (i % 4 == 1) ? 16'h8000 :
                    (i % 4 == 2) ? 16'h0000 : 16'hFFFF;
        default: mem[i] = 16'h8000 | DW'($urandom);
      endcase
      orig[i] = mem[i];
      wcnt[i] = 0;
    end
    rd_hist.delete();
    rd_n = 0; wr_n = 0; busy_n = 0; exp_rd = 0; exp_wr = 0; done_n = 0; stray = 0;
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk);
    first_busy = busy;
    check(first_busy == 1, "R2 busy after start", first_busy, 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      #1 start = 1; @(posedge clk); #1 start = 0;
    end
    while (!done) @(negedge clk);
    repeat (6) @(negedge clk);
    check(rd_n == N, "R2 read count", rd_n, N);
    check(wr_n == N, poke ? "R8 write count" : "R5 write count", wr_n, N);
    check(busy_n == N + L + 1, poke ? "R8 busy length" : "R6 busy length", busy_n, N + L + 1);
    check(done_cyc - last_wr == 2, "R6 done after last write", done_cyc - last_wr, 2);
    check(done_n == 1, "R6 single done", done_n, 1);
    check(!stray, "R7 access outside busy", stray, 0);
    for (int i = 0; i < N; i++) begin
      check(wcnt[i] == 1, "R5 writes per address", wcnt[i], 1);
      check(mem[i] === relu(orig[i]), "R4 final value", mem[i], relu(orig[i]));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < L; i++) rq[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_en && !wr_en, "R1 reset outputs",
          {busy, done, rd_en, wr_en}, 0);
    #1 rst_n = 1;
    run(1, 0);
    run(0, 0);
    run(2, 0);
    run(0, 1);
    run(0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule